// File: doc/BRIEF.md
# Scan Test Data Register Bank

This block holds the test data registers that sit between the serial input and the serial output of a boundary-scan test access port. A TAP controller and an instruction decoder, both outside the block, deliver a capture strobe, a shift strobe and a two-bit selection code. On each rising edge of the test clock the block updates the selected register. It drives the serial output from a flop clocked on the falling edge, as the scan protocol expects.

There are three registers. The one-stage pass-through register lets a device in a long chain be skipped. The 32-bit identification register loads a constant built from a revision, a part code and a maker code. The one-bit reset register drives a system reset request straight from its shift stage. No update stage sits in that path, so the request rises in the same test-clock cycle as the shifted-in 1. When the bit clears, a counter in the system clock domain keeps the request asserted for a further programmable number of system cycles. While the request is up, the block also raises a pin-disable output that floats the device pins. This lets a scan sequence isolate the pins without a dedicated high-impedance instruction.

Top module: `jtag_dr_bank`

## Requirements
- R1: The pass-through register is a single stage. A capture with it selected loads 0. Each shift step loads `tdi`, so `tdo` repeats `tdi` one test-clock cycle later.
- R2: The `dr_sel` code picks the register: 0 is pass-through, 1 is identification, 2 is reset. The unused code 3 behaves exactly as pass-through.
- R3: A capture with identification selected loads the 32-bit value. Bits 31:28 hold `ID_REV`, bits 27:12 hold `ID_PART`, bits 11:1 hold `ID_MAKER`, and bit 0 is 1.
- R4: A shift moves the identification register one bit per rising `tck`, least significant bit first. `tdi` enters at bit 31. After 32 shifts, the first bit shifted in appears at `tdo`.
- R5: `tdo` changes only on the falling edge of `tck`. A rising edge leaves it unchanged.
- R6: A shift with reset selected loads `tdi` into the reset bit. A 1 raises `sys_reset_req` before the next `sys_clk` edge after that `tck` rise. Captures, and shifts with another register selected, leave the bit unchanged.
- R7: `sys_reset_req` stays 1 for as long as the reset bit holds 1.
- R8: After the reset bit clears, `sys_reset_req` falls at the (`HOLD_CYCLES`+2)-th rising `sys_clk` edge: two synchroniser stages, then `HOLD_CYCLES` counts. With `HOLD_CYCLES` = 0 it falls immediately, with no `sys_clk` edge needed.
- R9: `pins_hiz` equals `sys_reset_req` at all times.
- R10: `tap_reset` high at a rising `tck` clears the reset bit and the pass-through register. It also reloads the identification register and drives `tdo` to 0 at the falling edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| tap_reset | input | 1 | Test-logic reset, synchronous to `tck`, active high |
| capture_dr | input | 1 | Capture strobe for the selected register |
| shift_dr | input | 1 | Shift strobe for the selected register |
| dr_sel | input | 2 | Register selection code from the instruction decoder |
| tdi | input | 1 | Serial test data in |
| tdo | output | 1 | Serial test data out, updated on falling `tck` |
| sys_clk | input | 1 | System clock for the reset hold-off counter |
| sys_rst | input | 1 | System-domain synchronous reset, active high |
| sys_reset_req | output | 1 | Request to hold the system in reset |
| pins_hiz | output | 1 | Pin disable, high while reset is requested |

## Verification
The assertions take for granted that `capture_dr` and `shift_dr` are never both high in one `tck` cycle. They also assume that `tap_reset` and `sys_rst` are both asserted before the first check, so that the reset bit and the counter start from known values. The stimulus drives one strobe per test-clock cycle from a task that takes a single step kind, and it holds both resets at the start. All input changes happen while `tck` is low and away from `sys_clk` edges. The hold-off window is measured while `tck` is still, so the synchroniser sees a single clean transition.

// File: rtl/jdr_pkg.sv
package jdr_pkg;
  localparam int REV_W   = 4;
  localparam int PART_W  = 16;
  localparam int MAKER_W = 11;
  localparam int ID_W    = REV_W + PART_W + MAKER_W + 1;

  localparam logic [1:0] SEL_BYPASS = 2'd0;
  localparam logic [1:0] SEL_IDENT  = 2'd1;
  localparam logic [1:0] SEL_RESET  = 2'd2;

  function automatic logic [ID_W-1:0] make_ident(
    input logic [REV_W-1:0]   rev,
    input logic [PART_W-1:0]  part,
    input logic [MAKER_W-1:0] maker
  );
    return {rev, part, maker, 1'b1};
  endfunction
endpackage

// File: rtl/jdr_bypass.sv
module jdr_bypass (
  input  logic tck,
  input  logic tap_reset,
  input  logic sel,
  input  logic capture,
  input  logic shift,
  input  logic tdi,
  output logic so
);
  always_ff @(posedge tck) begin
    if (tap_reset) begin
      so <= 1'b0;
    end else if (sel && capture) begin
      so <= 1'b0;
    end else if (sel && shift) begin
      so <= tdi;
    end
  end
endmodule

// File: rtl/jdr_ident.sv
module jdr_ident #(
  parameter int W = 32,
  parameter logic [W-1:0] VALUE = '1
) (
  input  logic         tck,
  input  logic         tap_reset,
  input  logic         sel,
  input  logic         capture,
  input  logic         shift,
  input  logic         tdi,
  output logic [W-1:0] sr,
  output logic         so
);
  always_ff @(posedge tck) begin
    if (tap_reset) begin
      sr <= VALUE;
    end else if (sel && capture) begin
      sr <= VALUE;
    end else if (sel && shift) begin
      sr <= {tdi, sr[W-1:1]};
    end
  end

  assign so = sr[0];
endmodule

// File: rtl/jdr_reset_bit.sv
module jdr_reset_bit (
  input  logic tck,
  input  logic tap_reset,
  input  logic sel,
  input  logic shift,
  input  logic tdi,
  output logic bit_q
);
  // No update latch: the shift stage is the reset request.
  always_ff @(posedge tck) begin
    if (tap_reset) begin
      bit_q <= 1'b0;
    end else if (sel && shift) begin
      bit_q <= tdi;
    end
  end
endmodule

// File: rtl/jdr_holdoff.sv
module jdr_holdoff #(
  parameter int HOLD_CYCLES = 4,
  parameter int CNT_W = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic             sys_clk,
  input  logic             sys_rst,
  input  logic             req_async,
  output logic [CNT_W-1:0] cnt,
  output logic             active
);
  logic [SYNC_STAGES-1:0] sync_q;

  generate
    if (HOLD_CYCLES == 0) begin : g_none
      always_ff @(posedge sys_clk) begin
        if (sys_rst) begin
          sync_q <= '0;
        end else begin
          sync_q <= {sync_q[SYNC_STAGES-2:0], req_async};
        end
      end
      assign cnt    = '0;
      assign active = 1'b0;
    end else begin : g_count
      always_ff @(posedge sys_clk) begin
        if (sys_rst) begin
          sync_q <= '0;
          cnt    <= '0;
        end else begin
          sync_q <= {sync_q[SYNC_STAGES-2:0], req_async};
          if (sync_q[SYNC_STAGES-1]) begin
            cnt <= CNT_W'(HOLD_CYCLES);
          end else if (cnt != '0) begin
            cnt <= cnt - 1'b1;
          end
        end
      end
      assign active = (cnt != '0);
    end
  endgenerate
endmodule

// File: rtl/jdr_tdo_out.sv
module jdr_tdo_out #(
  parameter int N = 3
) (
  input  logic         tck,
  input  logic         tap_reset,
  input  logic [N-1:0] onehot_sel,
  input  logic [N-1:0] src,
  output logic         tdo
);
  logic mux_out;

  always_comb begin
    mux_out = 1'b0;
    for (int i = 0; i < N; i++) begin
      if (onehot_sel[i]) mux_out = src[i];
    end
  end

  always_ff @(negedge tck) begin
    if (tap_reset) begin
      tdo <= 1'b0;
    end else begin
      tdo <= mux_out;
    end
  end
endmodule

// File: rtl/jtag_dr_bank.sv
module jtag_dr_bank #(
  parameter logic [3:0]  ID_REV      = 4'h0,
  parameter logic [15:0] ID_PART     = 16'h1234,
  parameter logic [10:0] ID_MAKER    = 11'h01F,
  parameter int          HOLD_CYCLES = 4
) (
  input  logic       tck,
  input  logic       tap_reset,
  input  logic       capture_dr,
  input  logic       shift_dr,
  input  logic [1:0] dr_sel,
  input  logic       tdi,
  output logic       tdo,
  input  logic       sys_clk,
  input  logic       sys_rst,
  output logic       sys_reset_req,
  output logic       pins_hiz
);
  import jdr_pkg::*;

  localparam int CNT_W = (HOLD_CYCLES > 0) ? $clog2(HOLD_CYCLES + 1) : 1;
  localparam logic [ID_W-1:0] ID_VALUE = make_ident(ID_REV, ID_PART, ID_MAKER);
  localparam int NREG = 3;

  logic             sel_ident, sel_reset, sel_bypass;
  logic             bp_bit, id_so, rst_bit, hold_active;
  logic [ID_W-1:0]  id_sr;
  logic [CNT_W-1:0] hold_cnt;

  assign sel_ident  = (dr_sel == SEL_IDENT);
  assign sel_reset  = (dr_sel == SEL_RESET);
  assign sel_bypass = !sel_ident && !sel_reset;

  jdr_bypass u_bypass (
    .tck(tck), .tap_reset(tap_reset), .sel(sel_bypass),
    .capture(capture_dr), .shift(shift_dr), .tdi(tdi), .so(bp_bit)
  );

  jdr_ident #(.W(ID_W), .VALUE(ID_VALUE)) u_ident (
    .tck(tck), .tap_reset(tap_reset), .sel(sel_ident),
    .capture(capture_dr), .shift(shift_dr), .tdi(tdi),
    .sr(id_sr), .so(id_so)
  );

  jdr_reset_bit u_rstbit (
    .tck(tck), .tap_reset(tap_reset), .sel(sel_reset),
    .shift(shift_dr), .tdi(tdi), .bit_q(rst_bit)
  );

  jdr_holdoff #(.HOLD_CYCLES(HOLD_CYCLES), .CNT_W(CNT_W), .SYNC_STAGES(2)) u_hold (
    .sys_clk(sys_clk), .sys_rst(sys_rst), .req_async(rst_bit),
    .cnt(hold_cnt), .active(hold_active)
  );

  jdr_tdo_out #(.N(NREG)) u_tdo (
    .tck(tck), .tap_reset(tap_reset),
    .onehot_sel({sel_reset, sel_ident, sel_bypass}),
    .src({rst_bit, id_so, bp_bit}),
    .tdo(tdo)
  );

  assign sys_reset_req = rst_bit | hold_active;
  assign pins_hiz      = rst_bit | hold_active;
endmodule

// File: rtl/jdr_bank_checks.sv
module jdr_bank_checks #(
  parameter int          ID_W        = 32,
  parameter logic [ID_W-1:0] ID_VALUE = '1,
  parameter int          HOLD_CYCLES = 4,
  parameter int          CNT_W       = 3
) (
  input logic             tck,
  input logic             tap_reset,
  input logic             capture_dr,
  input logic             shift_dr,
  input logic [1:0]       dr_sel,
  input logic             tdi,
  input logic             sys_clk,
  input logic             sys_rst,
  input logic             bp_bit,
  input logic [ID_W-1:0]  id_sr,
  input logic             rst_bit,
  input logic [CNT_W-1:0] hold_cnt,
  input logic             sys_reset_req,
  input logic             pins_hiz
);
  logic chk_sel_bp;
  assign chk_sel_bp = (dr_sel == 2'd0) || (dr_sel == 2'd3);

  // R1, R2: capture on the pass-through path clears it
  assert_bypass_capture_R1: assert property (@(posedge tck) disable iff (tap_reset)
    (capture_dr && !shift_dr && chk_sel_bp) |=> (bp_bit == 1'b0));

  // R3: identification capture loads the constant
  assert_ident_capture_R3: assert property (@(posedge tck) disable iff (tap_reset)
    (capture_dr && !shift_dr && dr_sel == 2'd1) |=> (id_sr == ID_VALUE));

  // R6: a shifted-in 1 on the reset path raises the request
  assert_reset_raise_R6: assert property (@(posedge tck) disable iff (tap_reset)
    (shift_dr && dr_sel == 2'd2 && tdi) |=> sys_reset_req);

  // R6: reset bit holds while another register is selected
  assert_reset_hold_R6: assert property (@(posedge tck) disable iff (tap_reset)
    (dr_sel != 2'd2) |=> $stable(rst_bit));

  // R7: request stays up while the bit is set
  assert_req_follows_R7: assert property (@(posedge sys_clk) disable iff (sys_rst || tap_reset)
    rst_bit |-> sys_reset_req);

  // R8: hold-off count never exceeds its limit
  assert_cnt_bound_R8: assert property (@(posedge sys_clk) disable iff (sys_rst)
    (hold_cnt <= CNT_W'(HOLD_CYCLES)));

  // R9: pin disable tracks the request
  assert_hiz_match_R9: assert property (@(posedge sys_clk) disable iff (sys_rst)
    (pins_hiz == sys_reset_req));
endmodule

bind jtag_dr_bank jdr_bank_checks #(
  .ID_W(jdr_pkg::ID_W), .ID_VALUE(ID_VALUE),
  .HOLD_CYCLES(HOLD_CYCLES), .CNT_W(CNT_W)
) u_checks (
  .tck(tck), .tap_reset(tap_reset), .capture_dr(capture_dr), .shift_dr(shift_dr),
  .dr_sel(dr_sel), .tdi(tdi), .sys_clk(sys_clk), .sys_rst(sys_rst),
  .bp_bit(bp_bit), .id_sr(id_sr), .rst_bit(rst_bit), .hold_cnt(hold_cnt),
  .sys_reset_req(sys_reset_req), .pins_hiz(pins_hiz)
);

// File: tb/test_jtag_dr_bank.sv
`timescale 1ns/1ps
module test_jtag_dr_bank;
  localparam logic [3:0]  REV   = 4'h3;
  localparam logic [15:0] PART  = 16'h9A5C;
  localparam logic [10:0] MAKER = 11'h01F;
  localparam int HOLD = 5;

  logic tck = 1'b0, sys_clk = 1'b0;
  logic tap_reset = 1'b1, sys_rst = 1'b1;
  logic capture_dr = 1'b0, shift_dr = 1'b0, tdi = 1'b0;
  logic [1:0] dr_sel = 2'd0;
  logic tdo_a, tdo_b, req_a, req_b, hiz_a, hiz_b;

  int n_checks = 0, n_fail = 0;
  logic tdo_rise, req_a_rise, req_b_rise;

  always #2.5 sys_clk = ~sys_clk;

  jtag_dr_bank #(.ID_REV(REV), .ID_PART(PART), .ID_MAKER(MAKER), .HOLD_CYCLES(HOLD)) i_jtag_dr_bank (
    .tck(tck), .tap_reset(tap_reset), .capture_dr(capture_dr), .shift_dr(shift_dr),
    .dr_sel(dr_sel), .tdi(tdi), .tdo(tdo_a), .sys_clk(sys_clk), .sys_rst(sys_rst),
    .sys_reset_req(req_a), .pins_hiz(hiz_a)
  );

  jtag_dr_bank #(.ID_REV(REV), .ID_PART(PART), .ID_MAKER(MAKER), .HOLD_CYCLES(0)) i_jtag_dr_bank_z (
    .tck(tck), .tap_reset(tap_reset), .capture_dr(capture_dr), .shift_dr(shift_dr),
    .dr_sel(dr_sel), .tdi(tdi), .tdo(tdo_b), .sys_clk(sys_clk), .sys_rst(sys_rst),
    .sys_reset_req(req_b), .pins_hiz(hiz_b)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // One test-clock cycle: inputs set at start, rise at +5, fall at +10.
  task automatic step(input logic cap, input logic sh, input logic [1:0] sel,
                      input logic d, input logic trst);
    capture_dr = cap; shift_dr = sh; dr_sel = sel; tdi = d; tap_reset = trst;
    #5 tck = 1'b1;
    #2 tdo_rise = tdo_a; req_a_rise = req_a; req_b_rise = req_b;
    #3 tck = 1'b0;
    #5;
  endtask

  initial begin : watchdog
    #500000;
    n_checks++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin : main
    logic [31:0] id_exp, pat;
    logic [7:0]  bpat;
    int n;
    id_exp = {REV, PART, MAKER, 1'b1};
    pat    = 32'hA5C3_0F69;
    bpat   = 8'b1011_0010;

    // reset both domains
    step(1'b0, 1'b0, 2'd0, 1'b0, 1'b1);
    step(1'b0, 1'b0, 2'd0, 1'b0, 1'b1);
    sys_rst = 1'b0;
    step(1'b0, 1'b0, 2'd0, 1'b0, 1'b0);
    chk("R10 tdo after reset", 32'(tdo_a), 32'd0);
    chk("R10 req after reset", 32'(req_a), 32'd0);
    chk("R10 zero-hold req after reset", 32'(req_b), 32'd0);
    chk("R9 hiz after reset", 32'(hiz_a), 32'd0);

    // R3 / R4: identification capture and shift-through
    step(1'b1, 1'b0, 2'd1, 1'b0, 1'b0);
    for (int i = 0; i < 32; i++) begin
      chk("R3 ident bit", 32'(tdo_a), 32'(id_exp[i]));
      step(1'b0, 1'b1, 2'd1, pat[i], 1'b0);
    end
    for (int i = 0; i < 32; i++) begin
      chk("R4 shifted-in bit", 32'(tdo_a), 32'(pat[i]));
      chk("R4 zero-hold instance tdo", 32'(tdo_b), 32'(pat[i]));
      step(1'b0, 1'b1, 2'd1, 1'b0, 1'b0);
    end

    // R1 / R2 / R5: pass-through on codes 0 and 3
    for (int s = 0; s < 2; s++) begin
      logic [1:0] code;
      logic prev;
      code = (s == 0) ? 2'd0 : 2'd3;
      step(1'b0, 1'b1, code, 1'b1, 1'b0);
      chk("R2 bypass code loads tdi", 32'(tdo_a), 32'd1);
      step(1'b1, 1'b0, code, 1'b1, 1'b0);
      chk("R1 capture loads zero", 32'(tdo_a), 32'd0);
      prev = tdo_a;
      for (int i = 0; i < 8; i++) begin
        step(1'b0, 1'b1, code, bpat[i], 1'b0);
        chk("R5 tdo steady at rise", 32'(tdo_rise), 32'(prev));
        chk("R1 one-stage delay", 32'(tdo_a), 32'(bpat[i]));
        prev = tdo_a;
      end
    end

    // R6: set the reset bit
    step(1'b0, 1'b1, 2'd2, 1'b1, 1'b0);
    chk("R6 req rises same cycle", 32'(req_a_rise), 32'd1);
    chk("R6 zero-hold req rises same cycle", 32'(req_b_rise), 32'd1);
    chk("R6 reset bit at tdo", 32'(tdo_a), 32'd1);
    step(1'b1, 1'b0, 2'd2, 1'b0, 1'b0);
    chk("R6 capture keeps bit", 32'(tdo_a), 32'd1);
    for (int i = 0; i < 3; i++) step(1'b0, 1'b1, 2'd0, 1'b0, 1'b0);
    chk("R6 unselected shift keeps bit", 32'(req_b), 32'd1);
    step(1'b0, 1'b0, 2'd2, 1'b0, 1'b0);
    chk("R6 bit still 1 at tdo", 32'(tdo_a), 32'd1);
    repeat (20) @(posedge sys_clk);
    #2.5;
    chk("R7 req held", 32'(req_a), 32'd1);
    chk("R7 zero-hold req held", 32'(req_b), 32'd1);
    chk("R9 hiz during reset", 32'(hiz_a), 32'd1);
    chk("R9 zero-hold hiz during reset", 32'(hiz_b), 32'd1);

    // R8: clear the bit and time the release
    capture_dr = 1'b0; shift_dr = 1'b1; dr_sel = 2'd2; tdi = 1'b0;
    #5 tck = 1'b1;
    #1;
    chk("R8 zero-hold immediate release", 32'(req_b), 32'd0);
    chk("R8 held instance still up", 32'(req_a), 32'd1);
    n = 0;
    while (req_a && n < 50) begin
      @(posedge sys_clk);
      #1 n++;
      if (req_a) chk("R9 hiz in hold-off", 32'(hiz_a), 32'd1);
    end
    chk("R8 release edge count", 32'(n), 32'(HOLD + 2));
    chk("R9 hiz after release", 32'(hiz_a), 32'd0);
    #1.5 tck = 1'b0;
    shift_dr = 1'b0;
    #5;

    // R10: tap_reset clears the reset bit
    step(1'b0, 1'b1, 2'd2, 1'b1, 1'b0);
    chk("R6 set again", 32'(req_b), 32'd1);
    step(1'b0, 1'b0, 2'd2, 1'b0, 1'b1);
    chk("R10 bit cleared", 32'(req_b_rise), 32'd0);
    chk("R10 tdo cleared", 32'(tdo_a), 32'd0);
    step(1'b0, 1'b0, 2'd2, 1'b0, 1'b0);
    repeat (HOLD + 6) @(posedge sys_clk);
    #2.5;
    chk("R10 held instance released", 32'(req_a), 32'd0);

    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule